// File: doc/BRIEF.md
# Memory-Map Mode Guard

This block sits beside the CPU bus and classifies every access strobe by address. It decides whether an address falls in the on-chip program store, the on-chip RAM/register window, external memory, or nowhere legal. For each strobe it raises exactly one registered output for one clock: a region select or a fault pulse. Every fault also sets a sticky flag, and only reset clears that flag.

The operating mode comes from two bits. The first is the external-memory pin, which is captured while reset is held and then frozen until the next reset. The second is an open-map control bit that software writes through a simple write strobe. With the pin low and the open-map bit low, the part runs single-chip with no external space, and any address outside the two on-chip windows is a fault. Setting the open-map bit turns the unused space into external memory and disables the fault. With the pin high, the program store is off chip: only the RAM window stays on chip, and no access ever faults.

Top module: `memmap_guard`

## Requirements
- R1: Reset is synchronous and active low. The external-memory pin is sampled at every clock edge while reset is low, so the last sampled value is the mode. Later changes of the pin have no effect until the next reset.
- R2: The open-map bit is 0 after reset. A write (`cfg_we_i`=1) loads `cfg_wdata_i`, and the new value governs accesses from the next cycle on.
- R3: In every mode, an access to 0x0000..0x02FF selects RAM (`sel_ram_o`). With the pin latched low, an access to 0xC000..0xFFFF selects the program store (`sel_prog_o`).
- R4: With the pin latched low and the open-map bit 0, an access to 0x0300..0xBFFF raises `fault_o` and no select.
- R5: With the pin latched low and the open-map bit 1, an access to 0x0300..0xBFFF raises `sel_ext_o` and no fault.
- R6: With the pin latched high, every address above 0x02FF, including 0xC000..0xFFFF, raises `sel_ext_o`. This holds for either value of the open-map bit, and no access faults.
- R7: All outputs are registered. They respond in the cycle after the strobe, stay high for one cycle per strobe, and are all low in a cycle that follows no strobe. Back-to-back strobes give back-to-back results.
- R8: At most one of `sel_prog_o`, `sel_ram_o`, `sel_ext_o` and `fault_o` is high in any cycle.
- R9: `fault_sticky_o` rises together with the first `fault_o` and stays high until reset. It is 0 after reset.
- R10: When a write to the open-map bit and an access happen in the same cycle, the access is judged with the old value of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ext_mode_i | input | 1 | External-memory mode pin, captured during reset |
| cfg_we_i | input | 1 | Write strobe for the open-map bit |
| cfg_wdata_i | input | 1 | New value of the open-map bit |
| acc_valid_i | input | 1 | Bus access strobe, one per access cycle |
| acc_addr_i | input | 16 | Access address |
| sel_prog_o | output | 1 | Program store selected (registered pulse) |
| sel_ram_o | output | 1 | RAM/register window selected (registered pulse) |
| sel_ext_o | output | 1 | External memory selected (registered pulse) |
| fault_o | output | 1 | Illegal access pulse |
| fault_sticky_o | output | 1 | Fault seen since reset |

## Verification
The assertions assume the following about the inputs:
- reset is held low for at least one clock edge, so the mode pin is captured before any check starts;
- the strobe, address and write inputs have known values at every sampling edge.

They also relate each output to the strobe and mode of the previous cycle, so they take one result per strobe cycle as given. The stimulus changes inputs only on falling edges and holds reset for two edges, keeping the address at a defined value throughout. During reset it moves the pin between those two edges, so that the last-sample rule is exercised.

// File: rtl/memmap_pkg.sv
package memmap_pkg;

    // Encoding is {pin_latched, open_map}
    typedef enum logic [1:0] {
        MODE_SC_CLOSED = 2'b00,
        MODE_SC_OPEN   = 2'b01,
        MODE_XP_CLOSED = 2'b10,
        MODE_XP_OPEN   = 2'b11
    } op_mode_e;

    typedef enum logic [2:0] {
        RGN_NONE    = 3'd0,
        RGN_PROG    = 3'd1,
        RGN_RAM     = 3'd2,
        RGN_EXT     = 3'd3,
        RGN_ILLEGAL = 3'd4
    } region_e;

endpackage

// File: rtl/memmap_mode_reg.sv
module memmap_mode_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_mode_i,
    input  logic cfg_we_i,
    input  logic cfg_wdata_i,
    output logic pin_q_o,
    output logic open_q_o
);

    typedef struct packed {
        logic pin;
        logic open_map;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_ni) begin
            // pin keeps following the input while reset is low
            st_d.pin      = ext_mode_i;
            st_d.open_map = 1'b0;
        end else if (cfg_we_i) begin
            st_d.open_map = cfg_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pin_q_o  = st_q.pin;
    assign open_q_o = st_q.open_map;

endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
    import memmap_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RAM_LAST   = 16'h02FF,
    parameter logic [ADDR_W-1:0] PROG_FIRST = 16'hC000
) (
    input  op_mode_e          mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o
);

    logic in_ram;
    logic in_prog;

    assign in_ram  = (addr_i <= RAM_LAST);
    assign in_prog = (addr_i >= PROG_FIRST);

    always_comb begin
        region_o = RGN_NONE;
        unique case (mode_i)
            MODE_SC_CLOSED: begin
                if (in_ram)       region_o = RGN_RAM;
                else if (in_prog) region_o = RGN_PROG;
                else              region_o = RGN_ILLEGAL;
            end
            MODE_SC_OPEN: begin
                if (in_ram)       region_o = RGN_RAM;
                else if (in_prog) region_o = RGN_PROG;
                else              region_o = RGN_EXT;
            end
            MODE_XP_CLOSED, MODE_XP_OPEN: begin
                if (in_ram)       region_o = RGN_RAM;
                else              region_o = RGN_EXT;
            end
            default: region_o = RGN_NONE;
        endcase
    end

endmodule

// File: rtl/memmap_fault_trk.sv
module memmap_fault_trk
    import memmap_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    acc_valid_i,
    input  region_e region_i,
    output logic    sel_prog_o,
    output logic    sel_ram_o,
    output logic    sel_ext_o,
    output logic    fault_o,
    output logic    sticky_o
);

    typedef struct packed {
        logic prog;
        logic ram;
        logic ext;
        logic fault;
        logic sticky;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prog   = acc_valid_i && (region_i == RGN_PROG);
        st_d.ram    = acc_valid_i && (region_i == RGN_RAM);
        st_d.ext    = acc_valid_i && (region_i == RGN_EXT);
        st_d.fault  = acc_valid_i && (region_i == RGN_ILLEGAL);
        st_d.sticky = st_q.sticky | st_d.fault;
        if (!rst_ni) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign sel_prog_o = st_q.prog;
    assign sel_ram_o  = st_q.ram;
    assign sel_ext_o  = st_q.ext;
    assign fault_o    = st_q.fault;
    assign sticky_o   = st_q.sticky;

endmodule

// File: rtl/memmap_guard.sv
module memmap_guard
    import memmap_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] RAM_LAST   = 16'h02FF,
    parameter logic [ADDR_W-1:0] PROG_FIRST = 16'hC000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_mode_i,
    input  logic              cfg_we_i,
    input  logic              cfg_wdata_i,
    input  logic              acc_valid_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    output logic              sel_prog_o,
    output logic              sel_ram_o,
    output logic              sel_ext_o,
    output logic              fault_o,
    output logic              fault_sticky_o
);

    logic     pin_q;
    logic     open_q;
    op_mode_e mode;
    region_e  region;

    memmap_mode_reg mode_reg_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .ext_mode_i  (ext_mode_i),
        .cfg_we_i    (cfg_we_i),
        .cfg_wdata_i (cfg_wdata_i),
        .pin_q_o     (pin_q),
        .open_q_o    (open_q)
    );

    assign mode = op_mode_e'({pin_q, open_q});

    memmap_region_dec #(
        .ADDR_W     (ADDR_W),
        .RAM_LAST   (RAM_LAST),
        .PROG_FIRST (PROG_FIRST)
    ) dec_i (
        .mode_i   (mode),
        .addr_i   (acc_addr_i),
        .region_o (region)
    );

    memmap_fault_trk trk_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .acc_valid_i (acc_valid_i),
        .region_i    (region),
        .sel_prog_o  (sel_prog_o),
        .sel_ram_o   (sel_ram_o),
        .sel_ext_o   (sel_ext_o),
        .fault_o     (fault_o),
        .sticky_o    (fault_sticky_o)
    );

endmodule

// File: rtl/memmap_guard_chk.sv
module memmap_guard_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic acc_valid_i,
    input logic sel_prog_o,
    input logic sel_ram_o,
    input logic sel_ext_o,
    input logic fault_o,
    input logic fault_sticky_o,
    input logic pin_q,
    input logic open_q
);

    // R8
    a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({sel_prog_o, sel_ram_o, sel_ext_o, fault_o}));

    // R7
    a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(acc_valid_i)) |-> !(sel_prog_o || sel_ram_o || sel_ext_o || fault_o));

    // R7
    a_r7_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(acc_valid_i)) |-> $onehot({sel_prog_o, sel_ram_o, sel_ext_o, fault_o}));

    // R1
    a_r1_pin_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> $stable(pin_q));

    // R4
    a_r4_fault_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> $past(!pin_q && !open_q));

    // R5
    a_r5_ext_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_ext_o |-> $past(pin_q || open_q));

    // R6
    a_r6_no_prog_offchip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_prog_o |-> !$past(pin_q));

    // R9
    a_r9_sticky_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_o |-> fault_sticky_o);

    // R9
    a_r9_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_sticky_o |=> fault_sticky_o);

endmodule

bind memmap_guard memmap_guard_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .acc_valid_i    (acc_valid_i),
    .sel_prog_o     (sel_prog_o),
    .sel_ram_o      (sel_ram_o),
    .sel_ext_o      (sel_ext_o),
    .fault_o        (fault_o),
    .fault_sticky_o (fault_sticky_o),
    .pin_q          (pin_q),
    .open_q         (open_q)
);

// File: tb/memmap_guard_tb_top.sv
module memmap_guard_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_wdata = 1'b0;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = 16'h0000;
    logic        sel_prog, sel_ram, sel_ext, fault, sticky;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    memmap_guard dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .ext_mode_i     (ext_mode),
        .cfg_we_i       (cfg_we),
        .cfg_wdata_i    (cfg_wdata),
        .acc_valid_i    (acc_valid),
        .acc_addr_i     (acc_addr),
        .sel_prog_o     (sel_prog),
        .sel_ram_o      (sel_ram),
        .sel_ext_o      (sel_ext),
        .fault_o        (fault),
        .fault_sticky_o (sticky)
    );

    // result codes: 0 none, 1 program, 2 RAM, 3 external, 4 fault
    localparam int NVEC = 13;
    // {open_map, addr, expected code}, external-memory pin latched low
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 16'h0000, 3'd2},
        {1'b0, 16'h02FF, 3'd2},
        {1'b0, 16'hC000, 3'd1},
        {1'b0, 16'hFFFF, 3'd1},
        {1'b0, 16'h0300, 3'd4},
        {1'b0, 16'h8000, 3'd4},
        {1'b0, 16'hBFFF, 3'd4},
        {1'b1, 16'h0000, 3'd2},
        {1'b1, 16'h02FF, 3'd2},
        {1'b1, 16'h0300, 3'd3},
        {1'b1, 16'hBFFF, 3'd3},
        {1'b1, 16'hC000, 3'd1},
        {1'b1, 16'hFFFF, 3'd1}
    };

    function automatic int out_code();
        if (fault)         return 4;
        else if (sel_ext)  return 3;
        else if (sel_ram)  return 2;
        else if (sel_prog) return 1;
        return 0;
    endfunction

    task automatic check_out(input string req, input int exp);
        int got;
        int n;
        got = out_code();
        n = int'(sel_prog) + int'(sel_ram) + int'(sel_ext) + int'(fault);
        checks++;
        if (got != exp || n > 1) begin
            failures++;
            $display("FAIL %s got=%0d (active=%0d) exp=%0d", req, got, n, exp);
        end
    endtask

    task automatic check_sticky(input string req, input logic exp);
        checks++;
        if (sticky !== exp) begin
            failures++;
            $display("FAIL %s sticky got=%0b exp=%0b", req, sticky, exp);
        end
    endtask

    task automatic do_reset(input logic pin_early, input logic pin_last);
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0;
        cfg_we = 1'b0;
        ext_mode = pin_early;
        @(negedge clk);
        ext_mode = pin_last;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic access(input logic [15:0] a);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic write_open(input logic v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic cur_open;

        // Reset state
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        check_out("R7 reset outputs", 0);
        check_sticky("R9 reset", 1'b0);

        // Table walk, pin latched low
        cur_open = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][19] != cur_open) begin
                write_open(VEC[i][19]);
                cur_open = VEC[i][19];
            end
            access(VEC[i][18:3]);
            if (VEC[i][2:0] == 3'd4)      check_out("R4 table", int'(VEC[i][2:0]));
            else if (VEC[i][2:0] == 3'd3) check_out("R5 table", int'(VEC[i][2:0]));
            else                          check_out("R3 table", int'(VEC[i][2:0]));
        end
        check_sticky("R9 holds after legal accesses", 1'b1);

        // R2 / R10: default open-map bit and same-cycle write
        do_reset(1'b0, 1'b0);
        @(negedge clk);
        check_sticky("R9 cleared by reset", 1'b0);
        access(16'h4000);
        check_out("R2 default open bit is 0", 4);
        check_sticky("R9 set by fault", 1'b1);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = 1'b1;
        acc_valid = 1'b1;
        acc_addr = 16'h4000;
        @(negedge clk);
        cfg_we = 1'b0;
        acc_valid = 1'b0;
        check_out("R10 access with old open bit", 4);
        access(16'h4000);
        check_out("R2 open bit written to 1", 3);
        write_open(1'b0);
        access(16'h4000);
        check_out("R2 open bit written back to 0", 4);

        // R7: one-cycle pulse and back-to-back strobes
        access(16'h5000);
        check_out("R7 fault pulse", 4);
        @(negedge clk);
        check_out("R7 fault pulse ends", 0);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr = 16'h0000;
        @(negedge clk);
        acc_addr = 16'hC000;
        check_out("R7 first of back-to-back", 2);
        @(negedge clk);
        acc_valid = 1'b0;
        check_out("R7 second of back-to-back", 1);
        @(negedge clk);
        check_out("R7 idle after strobes", 0);

        // R1 / R6: pin high on the last reset edge, then moved low
        do_reset(1'b0, 1'b1);
        ext_mode = 1'b0;
        access(16'hC000);
        check_out("R1 latched pin ignores later change", 3);
        access(16'h4000);
        check_out("R6 middle space external", 3);
        access(16'h02FF);
        check_out("R6 RAM window", 2);
        access(16'h0300);
        check_out("R6 just above RAM", 3);
        write_open(1'b1);
        access(16'hFFFF);
        check_out("R6 open bit set, top external", 3);
        check_sticky("R6 no fault when pin high", 1'b0);

        // R1: pin high early in reset, low on the last edge
        do_reset(1'b1, 1'b0);
        ext_mode = 1'b1;
        access(16'hC000);
        check_out("R1 last sample wins", 1);
        access(16'h1000);
        check_out("R1 single-chip detection active", 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule